// File: doc/BRIEF.md
# I/O Processor Fault Capture and Termination Control

This block watches the error strobes of an input/output processor and turns them into two things: a decision about what happens to the I/O operation now in progress, and a status word that software reads later. It handles three fault kinds. A bus check is a disagreement, during a main-memory read, between the parity-error flag returned by the memory unit and the one from the processor's own checker. A control check is a parity error during a subchannel read. A memory interface error arrives on its own strobe.

A control check always ends the operation at once with an unusual-end indication. A bus check or memory interface error does the same when it hits a command fetch. When it hits a data access, the device is halted only if the current command carries its halt-on-transmission-error flag. Every fault sets a sticky bit in the status word and raises a processor fault indicator that stays up until it is cleared on its own input. The status word also holds the upper bits of the address of the command doubleword last fetched.

All pins are plain level or strobe signals sampled every clock. Nothing streams through the block, so there is no handshake and no back-pressure: every strobe is taken in the cycle it is high.

Top module: `iop_fault_ctl`

## Requirements
- R1: When `rd_vld_i` is high and `mem_perr_i` differs from `iop_perr_i`, the bus check bit (`status_o[30]`) is set one cycle later; when the two flags agree or `rd_vld_i` is low, it is not set.
- R2: A bus check or memory interface error with `cmd_fetch_i` high gives a one-cycle pulse on both `term_o` and `uend_o` one cycle later, whatever `hote_i` is.
- R3: A bus check or memory interface error with `cmd_fetch_i` low gives a one-cycle pulse on `halt_o` one cycle later only when `hote_i` is high, and on its own never drives `term_o` or `uend_o`.
- R4: `sub_perr_i` sets the control check bit (`status_o[29]`) and pulses `term_o` and `uend_o` one cycle later.
- R5: `mif_err_i` sets the memory interface error bit (`status_o[28]`) one cycle later and follows the termination rules of R2 and R3.
- R6: `pfi_o` rises one cycle after any fault, stays high through `clr_i`, and drops only one cycle after `pfi_clr_i` is pulsed with no fault in the same cycle.
- R7: `status_o[18:0]` equals `cmd_addr_i[23:5]` as captured in the last cycle with `rd_vld_i` and `cmd_fetch_i` both high, and holds in all other cycles.
- R8: Reserved status bits `status_o[31]` and `status_o[27:19]` always read zero.
- R9: Fault bits are sticky until `clr_i`; a fault in the same cycle as `clr_i` stays set, and simultaneous faults set all their bits in the same cycle.
- R10: After reset all outputs are zero, and `term_o`, `halt_o`, `uend_o` are high for exactly one cycle per faulting strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_vld_i | input | 1 | A main-memory read completes this cycle |
| cmd_fetch_i | input | 1 | 1: current access is a command fetch, 0: data access |
| mem_perr_i | input | 1 | Parity-error flag from the memory unit |
| iop_perr_i | input | 1 | Parity-error flag from the processor's checker |
| sub_perr_i | input | 1 | Parity error on a subchannel read |
| mif_err_i | input | 1 | Memory interface error strobe |
| hote_i | input | 1 | Halt-on-transmission-error flag of the current command |
| cmd_addr_i | input | 24 | Command doubleword address |
| clr_i | input | 1 | Clear the sticky fault bits |
| pfi_clr_i | input | 1 | Clear the processor fault indicator |
| term_o | output | 1 | Operation ends at once (pulse) |
| halt_o | output | 1 | Device halt (pulse) |
| uend_o | output | 1 | Unusual-end indication (pulse) |
| status_o | output | 32 | Fault bits, reserved zeros and command address |
| pfi_o | output | 1 | Processor fault indicator |

## Verification
Every result of this block lies exactly one register away from its strobe: the pulses, the fault bits, the fault indicator and the captured address all change on the first rising edge after the strobe cycle. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, so each check looks at the cycle the result is due in. Pulse width and stickiness are checked one further cycle later with the strobes removed.

// File: rtl/iop_fault_pkg.sv
package iop_fault_pkg;
  localparam int STAT_W  = 32;
  localparam int BCF_POS = 30;
  localparam int CCF_POS = 29;
  localparam int MIE_POS = 28;
  localparam int RSV_HI  = 27;
  localparam int RSV_LO  = 19;

  typedef struct packed {
    logic bcf;
    logic ccf;
    logic mie;
  } fault_vec_t;
endpackage

// File: rtl/iop_fault_classify.sv
module iop_fault_classify
  import iop_fault_pkg::*;
(
  input  logic       rd_vld_i,
  input  logic       cmd_fetch_i,
  input  logic       mem_perr_i,
  input  logic       iop_perr_i,
  input  logic       sub_perr_i,
  input  logic       mif_err_i,
  input  logic       hote_i,
  output fault_vec_t ev_o,
  output logic       end_now_o,
  output logic       halt_req_o,
  output logic       any_o
);
  logic mem_side;

  always_comb begin
    ev_o.bcf   = rd_vld_i & (mem_perr_i ^ iop_perr_i);
    ev_o.ccf   = sub_perr_i;
    ev_o.mie   = mif_err_i;
    // bus check and interface error share one routing rule
    mem_side   = ev_o.bcf | ev_o.mie;
    end_now_o  = ev_o.ccf | (mem_side & cmd_fetch_i);
    halt_req_o = mem_side & ~cmd_fetch_i & hote_i;
    any_o      = |ev_o;
  end
endmodule

// File: rtl/iop_fault_status.sv
module iop_fault_status
  import iop_fault_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int KEEP_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fault_vec_t        ev_i,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int ADDR_LSB = ADDR_W - KEEP_W;

  fault_vec_t        sticky_q;
  logic [KEEP_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else begin
      // a new fault outranks a clear in the same cycle
      sticky_q <= (clr_i ? fault_vec_t'('0) : sticky_q) | ev_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_i) begin
      addr_q <= addr_i[ADDR_W-1:ADDR_LSB];
    end
  end

  always_comb begin
    status_o                = '0;
    status_o[BCF_POS]       = sticky_q.bcf;
    status_o[CCF_POS]       = sticky_q.ccf;
    status_o[MIE_POS]       = sticky_q.mie;
    status_o[KEEP_W-1:0]    = addr_q;
  end
endmodule

// File: rtl/iop_fault_pulse.sv
module iop_fault_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic end_now_i,
  input  logic halt_req_i,
  input  logic any_i,
  input  logic pfi_clr_i,
  output logic term_o,
  output logic halt_o,
  output logic uend_o,
  output logic pfi_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_o <= 1'b0;
      uend_o <= 1'b0;
      halt_o <= 1'b0;
      pfi_o  <= 1'b0;
    end else begin
      term_o <= end_now_i;
      uend_o <= end_now_i;
      halt_o <= halt_req_i;
      pfi_o  <= any_i | (pfi_o & ~pfi_clr_i);
    end
  end
endmodule

// File: rtl/iop_fault_ctl.sv
module iop_fault_ctl
  import iop_fault_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int KEEP_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld_i,
  input  logic              cmd_fetch_i,
  input  logic              mem_perr_i,
  input  logic              iop_perr_i,
  input  logic              sub_perr_i,
  input  logic              mif_err_i,
  input  logic              hote_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              clr_i,
  input  logic              pfi_clr_i,
  output logic              term_o,
  output logic              halt_o,
  output logic              uend_o,
  output logic [31:0]       status_o,
  output logic              pfi_o
);
  fault_vec_t ev;
  logic       end_now, halt_req, any_flt, addr_ld;

  assign addr_ld = rd_vld_i & cmd_fetch_i;

  iop_fault_classify u_cls (
    .rd_vld_i   (rd_vld_i),
    .cmd_fetch_i(cmd_fetch_i),
    .mem_perr_i (mem_perr_i),
    .iop_perr_i (iop_perr_i),
    .sub_perr_i (sub_perr_i),
    .mif_err_i  (mif_err_i),
    .hote_i     (hote_i),
    .ev_o       (ev),
    .end_now_o  (end_now),
    .halt_req_o (halt_req),
    .any_o      (any_flt)
  );

  iop_fault_status #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .clr_i   (clr_i),
    .ld_i    (addr_ld),
    .addr_i  (cmd_addr_i),
    .status_o(status_o)
  );

  iop_fault_pulse u_pls (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_now_i (end_now),
    .halt_req_i(halt_req),
    .any_i     (any_flt),
    .pfi_clr_i (pfi_clr_i),
    .term_o    (term_o),
    .halt_o    (halt_o),
    .uend_o    (uend_o),
    .pfi_o     (pfi_o)
  );
endmodule

// File: rtl/iop_fault_ctl_chk.sv
module iop_fault_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_vld_i,
  input logic        cmd_fetch_i,
  input logic        mem_perr_i,
  input logic        iop_perr_i,
  input logic        sub_perr_i,
  input logic        mif_err_i,
  input logic        hote_i,
  input logic        clr_i,
  input logic        pfi_clr_i,
  input logic        term_o,
  input logic        halt_o,
  input logic        uend_o,
  input logic [31:0] status_o,
  input logic        pfi_o
);
  assert_bcf_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld_i && (mem_perr_i != iop_perr_i)) |=> status_o[30]);

  assert_fetch_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fetch_i && (mif_err_i || (rd_vld_i && (mem_perr_i != iop_perr_i))))
      |=> (term_o && uend_o));

  assert_data_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_fetch_i && hote_i && mif_err_i) |=> halt_o);

  assert_no_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fetch_i || !hote_i) |=> !halt_o);

  assert_ccf_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_perr_i |=> (term_o && uend_o && status_o[29]));

  assert_mie_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mif_err_i |=> status_o[28]);

  assert_pfi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pfi_o && !pfi_clr_i) |=> pfi_o);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_vld_i && cmd_fetch_i) |=> $stable(status_o[18:0]));

  always_comb begin
    assert_rsv_zero_R8: assert (!rst_n || (status_o[31] == 1'b0 && status_o[27:19] == '0));
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[30] && !clr_i) |=> status_o[30]);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (term_o && !sub_perr_i && !mif_err_i && !rd_vld_i) |=> !term_o);
endmodule

bind iop_fault_ctl iop_fault_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_vld_i(rd_vld_i), .cmd_fetch_i(cmd_fetch_i),
  .mem_perr_i(mem_perr_i), .iop_perr_i(iop_perr_i), .sub_perr_i(sub_perr_i),
  .mif_err_i(mif_err_i), .hote_i(hote_i), .clr_i(clr_i), .pfi_clr_i(pfi_clr_i),
  .term_o(term_o), .halt_o(halt_o), .uend_o(uend_o), .status_o(status_o),
  .pfi_o(pfi_o)
);

// File: tb/iop_fault_ctl_tb_top.sv
`timescale 1ns/1ps
module iop_fault_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_vld_i, cmd_fetch_i, mem_perr_i, iop_perr_i;
  logic        sub_perr_i, mif_err_i, hote_i, clr_i, pfi_clr_i;
  logic [23:0] cmd_addr_i;
  logic        term_o, halt_o, uend_o, pfi_o;
  logic [31:0] status_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  iop_fault_ctl dut_i (.*);

  // stim {rd,mem,iop,fetch,sub,mif,hote} ; exp {term,halt,uend,bcf,ccf,mie}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {7'b1100000, 6'b000_100},  // R1 R3 data bus check, no halt flag
    {7'b1100001, 6'b010_100},  // R3 data bus check with halt flag
    {7'b1011000, 6'b101_100},  // R2 fetch bus check
    {7'b1110000, 6'b000_000},  // R1 flags agree
    {7'b0100000, 6'b000_000},  // R1 no read in progress
    {7'b0000100, 6'b101_010},  // R4 subchannel parity
    {7'b0000010, 6'b000_001},  // R5 data interface error, no halt flag
    {7'b0001011, 6'b101_001},  // R5 R2 fetch interface error, flag ignored
    {7'b0000011, 6'b010_001},  // R5 R3 data interface error with flag
    {7'b1101110, 6'b101_111},  // R9 all three at once on fetch
    {7'b1100101, 6'b111_110}   // R9 R3 R4 data bus check plus subchannel
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic idle();
    {rd_vld_i, mem_perr_i, iop_perr_i, cmd_fetch_i, sub_perr_i, mif_err_i, hote_i} = '0;
    clr_i = 1'b0; pfi_clr_i = 1'b0;
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  function automatic logic [5:0] obs();
    return {term_o, halt_o, uend_o, status_o[30], status_o[29], status_o[28]};
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cmd_addr_i = '0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset outputs", {25'd0, term_o, halt_o, uend_o, pfi_o, 3'd0}, 32'd0);
    check("R10 reset status", status_o, 32'd0);

    for (int i = 0; i < NV; i++) begin
      clr_i = 1'b1; pfi_clr_i = 1'b1;
      step();
      idle();
      {rd_vld_i, mem_perr_i, iop_perr_i, cmd_fetch_i, sub_perr_i, mif_err_i, hote_i} = VEC[i][12:6];
      step();
      idle();
      check($sformatf("R1-vector %0d result", i), {26'd0, obs()}, {26'd0, VEC[i][5:0]});
      check($sformatf("R6 vector %0d pfi", i), {31'd0, pfi_o}, {31'd0, |VEC[i][2:0]});
    end

    // R10 pulses last one cycle, R9 bits stay
    clr_i = 1'b1; pfi_clr_i = 1'b1; step(); idle();
    sub_perr_i = 1'b1; step(); idle();
    check("R10 pulse high", {29'd0, term_o, uend_o, halt_o}, {29'd0, 3'b110});
    step();
    check("R10 pulse gone", {29'd0, term_o, uend_o, halt_o}, 32'd0);
    repeat (3) step();
    check("R9 sticky ccf", {31'd0, status_o[29]}, 32'd1);

    // R6 pfi survives clr_i, R9 clr clears bits
    clr_i = 1'b1; step(); idle();
    check("R9 cleared", {29'd0, status_o[30:28]}, 32'd0);
    check("R6 pfi survives clr", {31'd0, pfi_o}, 32'd1);
    pfi_clr_i = 1'b1; step(); idle();
    check("R6 pfi cleared", {31'd0, pfi_o}, 32'd0);

    // R9 fault and clear together: fault wins; R6 fault and pfi clear together
    clr_i = 1'b1; pfi_clr_i = 1'b1; mif_err_i = 1'b1; step(); idle();
    check("R9 set beats clear", {29'd0, status_o[30:28]}, 32'd1);
    check("R6 set beats clear", {31'd0, pfi_o}, 32'd1);

    // R7 address capture and hold
    cmd_addr_i = 24'hABCDE7; rd_vld_i = 1'b1; cmd_fetch_i = 1'b1; step(); idle();
    check("R7 address load", {13'd0, status_o[18:0]}, {13'd0, 19'(24'hABCDE7 >> 5)});
    cmd_addr_i = 24'h123456; rd_vld_i = 1'b1; step(); idle();
    check("R7 hold on data read", {13'd0, status_o[18:0]}, {13'd0, 19'(24'hABCDE7 >> 5)});
    cmd_fetch_i = 1'b1; step(); idle();
    check("R7 hold without read", {13'd0, status_o[18:0]}, {13'd0, 19'(24'hABCDE7 >> 5)});
    cmd_addr_i = 24'hFFFFFF; rd_vld_i = 1'b1; cmd_fetch_i = 1'b1; mem_perr_i = 1'b1;
    step(); idle();
    check("R8 reserved zero", {22'd0, status_o[31], status_o[27:19]}, 32'd0);
    check("R7 full address", {13'd0, status_o[18:0]}, {13'd0, 19'h7FFFF});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule